// File: doc/BRIEF.md
# Third-Order Nine-Level Noise-Shaping Modulator

This block is the digital front end of an oversampled digital-to-analog converter. Each accepted 16-bit signed sample, plus a signed offset word, goes into a loop of three delayed integrators. The loop's quantized output is fed back into all three integrators. The quantizer reads the last integrator, scales it and clamps the result to one of nine levels, -4 to +4. The level leaves the block as a 4-bit two's-complement code, and a multi-element analog converter downstream takes it. The loop pushes quantization error out of the signal band, towards high frequencies.

One loop step happens on each clock edge where the enable strobe is high. The strobe therefore sets the oversampled rate. Typical ratios are 64, 128 or 256 steps per signal sample, and the input sample is held between signal updates. All loop coefficients are compile-time parameters.

The feedback gains A1, A2 and A3 are integers. The forward gains c1, c2 and the quantizer gain c3 are each a numerator divided by a power of two. Every gain is built from shifts and adds. The integrators carry guard bits and clamp at their signed limits instead of wrapping. A synchronous reset clears the loop.

Top module: `dsm3_modulator`

## Requirements
- R1: While `rst_i` is high at a clock edge, all three integrators and the output register clear. This takes precedence over `en_i`. After reset, with a zero sum of input and offset, `s_o` stays 0.
- R2: `s_o` is a 4-bit two's-complement code and always holds a value from -4 to +4.
- R3: On each edge with `en_i` high, the level S = clamp(floor(x3·C3N / 2^C3S), -4, +4) is registered. S is computed from x3 as it was before that edge, and it appears on `s_o` right after that edge.
- R4: On the same edge, x3 becomes sat(x3 + floor(x2·C2N / 2^C2S) - A3·S). All operands are the values from before the edge.
- R5: On the same edge, x2 becomes sat(x2 + floor(x1·C1N / 2^C1S) - A2·S). All operands are the values from before the edge.
- R6: On the same edge, x1 becomes sat(x1 + U - A1·S). Here U is the sign-extended sum of `u_i` and `ofs_i`.
- R7: The integrators are IW = 16 + GUARD bits wide. sat() clamps a result to the range -2^(IW-1) to 2^(IW-1)-1 and never wraps.
- R8: On an edge with `en_i` low, `s_o` and all integrator states keep their values, whatever the data inputs are.
- R9: `ofs_i` acts only through the sum U. A pair (`u_i`=a, `ofs_i`=-a) gives the same output sequence as zero input, which is a constant 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Loop-step strobe (oversampled rate) |
| u_i | input | 16 | Signed input sample |
| ofs_i | input | 16 | Signed offset added to the input |
| s_o | output | 4 | Signed output level, -4..+4 |

## Verification
The bench runs two instances side by side. One uses balanced default gains. The other has weak feedback and few guard bits, so its integrators reach their limits. Both are driven with a sweep of constant inputs across the full signed range, a slow ramp, and a full-scale alternating pattern. Each step of each pattern is compared with an arithmetic model of the loop equations.

- The constant inputs show whether the update order and the use of old values are right. The average of the output levels must follow the input level.
- The alternating pattern stresses the quantizer clamp at both ends.
- Offset pairs that cancel must give silence, which separates the offset path from the sample path.
- Full-scale input plus full-scale offset drives the narrow instance into saturation. An integrator that wrapped would flip the sign of the output.
- Gated steps with changing data show whether the enable really freezes the loop.
- A reset in the middle of a run shows whether every state clears.

// File: rtl/dsm3_pkg.sv
package dsm3_pkg;
    localparam int LVL_W   = 4;
    localparam int LVL_MAX = 4;
    typedef logic signed [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dsm3_cmul.sv
// Constant gain y = floor(a * N / 2^SH) built only from shifts and adds.
module dsm3_cmul #(
    parameter int IW = 16,
    parameter int OW = 16,
    parameter int N  = 1,
    parameter int SH = 0
) (
    input  logic signed [IW-1:0] a,
    output logic signed [OW-1:0] y
);
    localparam int NB = (N < 2) ? 1 : $clog2(N + 1);
    localparam int PW = IW + NB + 1;

    logic signed [PW-1:0] part [0:NB];
    logic signed [PW-1:0] shifted;

    assign part[0] = '0;

    for (genvar b = 0; b < NB; b++) begin : g_bit
        if (((N >> b) & 1) == 1) begin : g_on
            assign part[b+1] = part[b] + (PW'(a) <<< b);
        end else begin : g_off
            assign part[b+1] = part[b];
        end
    end

    assign shifted = part[NB] >>> SH;
    assign y       = OW'(shifted);
endmodule

// File: rtl/dsm3_quant.sv
// Nine-level saturating quantizer.
module dsm3_quant
    import dsm3_pkg::*;
#(
    parameter int W = 24
) (
    input  logic signed [W-1:0] v,
    output lvl_t                s
);
    localparam logic signed [W-1:0] TOP = W'(LVL_MAX);
    localparam logic signed [W-1:0] BOT = -W'(LVL_MAX);

    always_comb begin
        if (v > TOP) begin
            s = lvl_t'(LVL_MAX);
        end else if (v < BOT) begin
            s = -lvl_t'(LVL_MAX);
        end else begin
            s = v[LVL_W-1:0];
        end
    end
endmodule

// File: rtl/dsm3_integ.sv
// Delayed, saturating integrator: x <= sat(x + add - sub) on each enabled step.
module dsm3_integ #(
    parameter int IW = 24
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic signed [IW+1:0] add_i,
    input  logic signed [IW+1:0] sub_i,
    output logic signed [IW-1:0] x_o
);
    localparam int SW = IW + 3;
    localparam logic signed [SW-1:0] HI = {4'b0000, {(IW-1){1'b1}}};
    localparam logic signed [SW-1:0] LO = {4'b1111, {(IW-1){1'b0}}};

    logic signed [SW-1:0] sum;
    logic signed [IW-1:0] nxt;

    always_comb begin
        sum = SW'(x_o) + SW'(add_i) - SW'(sub_i);
        if (sum > HI) begin
            nxt = HI[IW-1:0];
        end else if (sum < LO) begin
            nxt = LO[IW-1:0];
        end else begin
            nxt = sum[IW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            x_o <= '0;
        end else if (en_i) begin
            x_o <= nxt;
        end
    end
endmodule

// File: rtl/dsm3_modulator.sv
module dsm3_modulator
    import dsm3_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 8,
    parameter int A1    = 8192,
    parameter int A2    = 8192,
    parameter int A3    = 8192,
    parameter int C1N   = 1,
    parameter int C1S   = 1,
    parameter int C2N   = 1,
    parameter int C2S   = 1,
    parameter int C3N   = 1,
    parameter int C3S   = 13
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic signed [DW-1:0] u_i,
    input  logic signed [DW-1:0] ofs_i,
    output logic signed [3:0]    s_o
);
    localparam int IW = DW + GUARD;
    localparam int TW = IW + 2;

    logic signed [IW-1:0] x1_q, x2_q, x3_q;
    logic signed [IW-1:0] q_scaled;
    lvl_t                 s_now, s_q;
    logic signed [TW-1:0] fb1, fb2, fb3, g1, g2, uin;

    // quantizer path, driven by the pre-update x3
    dsm3_cmul #(.IW(IW), .OW(IW), .N(C3N), .SH(C3S)) u_c3 (.a(x3_q), .y(q_scaled));
    dsm3_quant #(.W(IW)) u_q (.v(q_scaled), .s(s_now));

    // feedback gains
    dsm3_cmul #(.IW(LVL_W), .OW(TW), .N(A1), .SH(0)) u_a1 (.a(s_now), .y(fb1));
    dsm3_cmul #(.IW(LVL_W), .OW(TW), .N(A2), .SH(0)) u_a2 (.a(s_now), .y(fb2));
    dsm3_cmul #(.IW(LVL_W), .OW(TW), .N(A3), .SH(0)) u_a3 (.a(s_now), .y(fb3));

    // forward gains between stages
    dsm3_cmul #(.IW(IW), .OW(TW), .N(C1N), .SH(C1S)) u_c1 (.a(x1_q), .y(g1));
    dsm3_cmul #(.IW(IW), .OW(TW), .N(C2N), .SH(C2S)) u_c2 (.a(x2_q), .y(g2));

    assign uin = TW'(u_i) + TW'(ofs_i);

    dsm3_integ #(.IW(IW)) u_i1 (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
        .add_i(uin), .sub_i(fb1), .x_o(x1_q)
    );
    dsm3_integ #(.IW(IW)) u_i2 (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
        .add_i(g1), .sub_i(fb2), .x_o(x2_q)
    );
    dsm3_integ #(.IW(IW)) u_i3 (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
        .add_i(g2), .sub_i(fb3), .x_o(x3_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else if (en_i) begin
            s_q <= s_now;
        end
    end

    assign s_o = s_q;
endmodule

// File: rtl/dsm3_chk.sv
module dsm3_chk #(
    parameter int DW = 16,
    parameter int IW = 24,
    parameter int A1 = 8192
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic signed [DW-1:0] u,
    input logic signed [DW-1:0] ofs,
    input logic signed [3:0]    s_o,
    input logic signed [IW-1:0] x1,
    input logic signed [IW-1:0] x3
);
    localparam logic signed [IW-1:0] HI = {1'b0, {(IW-1){1'b1}}};

    logic signed [DW:0] in_sum;
    logic               rst_d;

    assign in_sum = {u[DW-1], u} + {ofs[DW-1], ofs};

    always_ff @(posedge clk) begin
        rst_d <= rst;
        // R1
        if (rst_d) begin
            reset_clear_chk: assert (s_o == 4'sd0 && x1 == '0 && x3 == '0);
        end
    end

    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        (s_o >= -4'sd4 && s_o <= 4'sd4));

    // R3
    sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !x3[IW-1]) |=> !s_o[3]);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && x1 == HI && in_sum > (4 * A1)) |=> (x1 == HI));

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(s_o) && $stable(x1) && $stable(x3)));
endmodule

bind dsm3_modulator dsm3_chk #(.DW(DW), .IW(IW), .A1(A1)) u_chk (
    .clk(clk_i), .rst(rst_i), .en(en_i), .u(u_i), .ofs(ofs_i),
    .s_o(s_o), .x1(x1_q), .x3(x3_q)
);

// File: tb/sim_dsm3_modulator.sv
`timescale 1ns/1ps
module sim_dsm3_modulator;
    localparam int NI = 2;
    localparam int GRD [NI] = '{8, 2};
    localparam int AK  [NI] = '{8192, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic signed [15:0] u   = '0;
    logic signed [15:0] ofs = '0;
    logic signed [3:0]  s0, s1;

    int n_chk = 0;
    int n_bad = 0;
    longint mx [NI][3];
    int     last_s [NI];

    always #2 clk = ~clk;

    dsm3_modulator u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .u_i(u), .ofs_i(ofs), .s_o(s0)
    );
    dsm3_modulator #(.GUARD(2), .A1(1), .A2(1), .A3(1)) u1 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .u_i(u), .ofs_i(ofs), .s_o(s1)
    );

    task automatic chk(input string tag, input int k, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s inst%0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    function automatic longint satv(longint v, int iw);
        longint hi = (longint'(1) <<< (iw - 1)) - 1;
        longint lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // loop equations from the requirements: gains c1=c2=1/2, c3=1/8192
    task automatic model_step(input int k, input longint uin);
        longint q, x1, x2, x3;
        int iw = 16 + GRD[k];
        int s;
        x1 = mx[k][0]; x2 = mx[k][1]; x3 = mx[k][2];
        q = x3 >>> 13;
        s = (q > 4) ? 4 : (q < -4) ? -4 : int'(q);
        mx[k][2] = satv(x3 + (x2 >>> 1) - longint'(AK[k]) * s, iw);
        mx[k][1] = satv(x2 + (x1 >>> 1) - longint'(AK[k]) * s, iw);
        mx[k][0] = satv(x1 + uin - longint'(AK[k]) * s, iw);
        last_s[k] = s;
    endtask

    function automatic int outv(int k);
        return (k == 0) ? int'(s0) : int'(s1);
    endfunction

    // called just after a falling edge
    task automatic step(input int uv, input int ov, input bit e, input string tag);
        u = 16'(uv); ofs = 16'(ov); en = e;
        @(posedge clk);
        if (e) begin
            for (int k = 0; k < NI; k++) model_step(k, longint'(uv) + longint'(ov));
        end
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk(tag, k, outv(k), last_s[k]);
            chk("R2", k, int'(outv(k) >= -4 && outv(k) <= 4), 1);
        end
    endtask

    task automatic do_reset(input int uv);
        u = 16'(uv); ofs = 16'(uv); en = 1'b1; rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1", k, outv(k), 0);
            mx[k][0] = 0; mx[k][1] = 0; mx[k][2] = 0; last_s[k] = 0;
        end
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset wins over a busy input with en high
        do_reset(20000);
        for (int i = 0; i < 16; i++) step(0, 0, 1'b1, "R1");

        // R3/R4/R5/R6: constant-level sweep over the full signed range
        for (int v = -32768; v <= 32767; v += 4096) begin
            do_reset(0);
            for (int i = 0; i < 48; i++) step(v, 0, 1'b1, "R3");
        end
        do_reset(0);
        for (int i = 0; i < 48; i++) step(32767, 0, 1'b1, "R6");

        // R5: slow ramp
        do_reset(0);
        for (int i = 0; i < 256; i++) step(-32768 + i * 256, 0, 1'b1, "R5");

        // R4: full-scale alternation stresses the clamp
        do_reset(0);
        for (int i = 0; i < 128; i++) step((i % 2 == 0) ? 32767 : -32768, 0, 1'b1, "R4");

        // R9: cancelling offset gives silence; offset adds to input
        do_reset(0);
        for (int i = 0; i < 64; i++) begin
            step(12000, -12000, 1'b1, "R9");
            chk("R9", 0, int'(s0), 0);
        end
        for (int i = 0; i < 64; i++) step(-3000, 9000, 1'b1, "R9");

        // R8: gated steps with changing data
        do_reset(0);
        for (int i = 0; i < 96; i++) step(i * 700 - 30000, i * 13, (i % 3) != 0, "R8");

        // R7: drive the narrow instance into its integrator limits
        do_reset(0);
        for (int i = 0; i < 40; i++) step(32767, 32767, 1'b1, "R7");
        for (int i = 0; i < 40; i++) step(-32768, -32768, 1'b1, "R7");
        for (int i = 0; i < 40; i++) step(20000, 0, 1'b1, "R7");

        // R1: reset from a running state
        do_reset(0);
        for (int i = 0; i < 16; i++) step(0, 0, 1'b1, "R1");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule